// File: doc/BRIEF.md
# Set-Associative Cache Tag Profiler

This block models the tag side of an 8-way set-associative level-one data cache, so that the locality of an address stream can be measured without storing any data. A producer offers one byte address per cycle on a valid/ready handshake. The block splits each address into a line offset, a set index and a tag. It compares the tag against every way of the selected set in the same cycle and decides hit or miss. On a miss it claims a way, and it reports an eviction when that way held a live line.

Each accepted address gives one registered result in the following cycle. The result carries the hit and eviction flags, the set and the way. Three saturating counters keep a running total of hits, misses and evictions. A flush input empties the whole model and clears the counters in one cycle. Typical use is to replay loop address traces and compare miss rates for different strides and array placements.

Top module: `cache_tag_profiler`

## Requirements
- R1: Address bits [5:0] (the byte within a 64-byte line) take no part in the lookup: any byte of a resident line hits.
- R2: The set is address bits [11:6] (64 sets), and the response reports this index in `rsp_set`.
- R3: A hit needs a valid way whose stored tag equals all address bits above bit 11. A difference in any one tag bit gives a miss.
- R4: The first access to a line misses and fills it. Later accesses to that line hit for as long as it stays resident.
- R5: From an empty model, reading 129 consecutive bytes starting at address 4096 gives 3 misses and 126 hits.
- R6: A miss that replaces a valid line sets `rsp_evict` and increments the eviction count. A hit never sets `rsp_evict`. With a stride of 4096, every access after the eighth distinct line in a set evicts.
- R7: A miss fills the lowest-numbered invalid way of the set. If all ways are valid, it replaces the least recently used way, where both hits and fills count as uses. `rsp_way` reports the way that hit or was filled.
- R8: While no counter is saturated, hit count plus miss count equals the number of accepted requests. Each counter rises by exactly one on its event.
- R9: A cycle with `flush` high invalidates every line, resets the replacement order and zeroes all three counters. During that cycle `req_ready` is low and no request is accepted.
- R10: `rsp_valid` is high in exactly those cycles that follow an accepted request (`req_valid` and `req_ready` high at the clock edge). The response fields belong to that request.
- R11: Each counter (width `CNT_W`) stops at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the model and clear counters |
| req_valid | input | 1 | Request address offered |
| req_ready | output | 1 | Request can be taken (low during flush) |
| req_addr | input | ADDR_W | Byte address to look up |
| rsp_valid | output | 1 | Result of the previous accepted request |
| rsp_hit | output | 1 | Line was resident |
| rsp_evict | output | 1 | A valid line was replaced |
| rsp_set | output | INDEX_W | Set index used |
| rsp_way | output | log2(WAYS) | Way hit or filled |
| hit_count | output | CNT_W | Saturating hit total |
| miss_count | output | CNT_W | Saturating miss total |
| evict_count | output | CNT_W | Saturating eviction total |

## Verification
The hardest state to reach from the ports is a full set with a known age order, where a single further miss must pick one particular way. The stimulus fills one set through eight tags that differ only above bit 11. It then re-touches chosen lines to reorder recency and presents a new tag, so the victim way shows up directly in `rsp_way`. A long pseudo-random phase aims twelve tags at two sets, with idle cycles and occasional flushes, so that eviction chains and near-simultaneous reuse keep occurring. Counter saturation is reached by building the bench with narrow counters and hammering one resident line.

// File: rtl/cache_prof_pkg.sv
// Package: shared types and default geometry for the tag profiler.
// Assumes power-of-two way and set counts.
package cache_prof_pkg;

    // Default geometry: 64-byte lines, 64 sets, 8 ways, 32-bit addresses
    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_OFFSET_W = 6;
    localparam int DEF_INDEX_W  = 6;
    localparam int DEF_WAYS     = 8;
    localparam int DEF_CNT_W    = 32;

    // Outcome of one lookup
    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_FILL  = 2'd2,
        OUT_EVICT = 2'd3
    } outcome_e;

endpackage

// File: rtl/tag_match.sv
// Module: tag_match
// Compares one request tag against every way of a set in parallel.
// Assumes at most one valid way holds a given tag (the fill logic keeps it so).
module tag_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    logic [WAYS-1:0] match_vec;

    // One comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = way_valid[w] && (way_tags[w] == req_tag);
    end

    // Encode the matching way (unique by construction of the store)
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match_vec;

endmodule

// File: rtl/lru_victim.sv
// Module: lru_victim
// Picks the way to fill on a miss: lowest invalid way first, else the
// way whose age is the maximum (least recently used).
// Assumes ages of a set form a permutation of 0..WAYS-1.
module lru_victim #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][WAY_W-1:0] way_ages,
    output logic [WAY_W-1:0]           victim_way,
    output logic                       victim_live
);

    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] oldest_way;
    logic             any_free;

    // Lowest-numbered invalid way
    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) free_way = WAY_W'(w);
        end
    end

    // Way holding the highest age
    always_comb begin
        oldest_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_ages[w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
        end
    end

    assign any_free    = ~&way_valid;
    assign victim_way  = any_free ? free_way : oldest_way;
    assign victim_live = ~any_free;

endmodule

// File: rtl/lru_update.sv
// Module: lru_update
// Computes a set's new age vector after one way is used: that way becomes
// age 0, ways younger than it age by one, older ways are unchanged.
// Assumes ages form a permutation, which this update preserves.
module lru_update #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages_in,
    input  logic [WAY_W-1:0]           used_way,
    output logic [WAYS-1:0][WAY_W-1:0] ages_out
);

    logic [WAY_W-1:0] used_age;

    assign used_age = ages_in[used_way];

    // Per-way age step
    for (genvar w = 0; w < WAYS; w++) begin : g_age
        assign ages_out[w] = (used_way == WAY_W'(w)) ? '0 :
                             (ages_in[w] < used_age) ? ages_in[w] + 1'b1 :
                                                       ages_in[w];
    end

endmodule

// File: rtl/sat_counter.sv
// Module: sat_counter
// Event counter that clears on request and holds at all-ones.
// Assumes clear has priority over increment.
module sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    // Count with saturation
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/cache_tag_profiler.sv
// Module: cache_tag_profiler (top)
// Tag-only set-associative cache model. One lookup per cycle: set chosen
// from the index bits, all ways compared at once, miss fills lowest invalid
// way or the LRU way. Result registered one cycle after acceptance.
// Assumes power-of-two WAYS >= 2; the state lives in flops.
module cache_tag_profiler
    import cache_prof_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int OFFSET_W = DEF_OFFSET_W,
    parameter int INDEX_W  = DEF_INDEX_W,
    parameter int WAYS     = DEF_WAYS,
    parameter int CNT_W    = DEF_CNT_W,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_evict,
    output logic [INDEX_W-1:0] rsp_set,
    output logic [WAY_W-1:0]   rsp_way,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count,
    output logic [CNT_W-1:0]   evict_count
);

    localparam int SETS  = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - OFFSET_W - INDEX_W;

    // State arrays
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0] age_q   [SETS];

    // Lookup datapath
    logic                       accept;
    logic [INDEX_W-1:0]         req_set;
    logic [TAG_W-1:0]           req_tag;
    logic [WAYS-1:0]            sel_valid;
    logic [WAYS-1:0][TAG_W-1:0] sel_tags;
    logic [WAYS-1:0][WAY_W-1:0] sel_ages;
    logic [WAYS-1:0][WAY_W-1:0] next_ages;
    logic                       look_hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           victim_way;
    logic                       victim_live;
    logic [WAY_W-1:0]           use_way;
    outcome_e                   outcome;

    assign req_ready = ~flush;
    assign accept    = req_valid && req_ready;
    assign req_set   = req_addr[OFFSET_W +: INDEX_W];
    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign sel_valid = valid_q[req_set];
    assign sel_tags  = tag_q[req_set];
    assign sel_ages  = age_q[req_set];

    tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_tag_match (
        .way_valid (sel_valid),
        .way_tags  (sel_tags),
        .req_tag   (req_tag),
        .hit       (look_hit),
        .hit_way   (hit_way)
    );

    lru_victim #(.WAYS(WAYS)) i_lru_victim (
        .way_valid   (sel_valid),
        .way_ages    (sel_ages),
        .victim_way  (victim_way),
        .victim_live (victim_live)
    );

    assign use_way = look_hit ? hit_way : victim_way;

    lru_update #(.WAYS(WAYS)) i_lru_update (
        .ages_in  (sel_ages),
        .used_way (use_way),
        .ages_out (next_ages)
    );

    // Classify the current lookup
    always_comb begin
        if (!accept)          outcome = OUT_IDLE;
        else if (look_hit)    outcome = OUT_HIT;
        else if (victim_live) outcome = OUT_EVICT;
        else                  outcome = OUT_FILL;
    end

    // Valid bits and ages: reset/flush to empty with identity order
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (accept) begin
            valid_q[req_set][use_way] <= 1'b1;
            age_q[req_set]            <= next_ages;
        end
    end

    // Tag store: written only on a fill, needs no reset
    always_ff @(posedge clk) begin
        if (outcome == OUT_FILL || outcome == OUT_EVICT) begin
            tag_q[req_set][use_way] <= req_tag;
        end
    end

    // Registered lookup result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_evict <= 1'b0;
            rsp_set   <= '0;
            rsp_way   <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_hit   <= (outcome == OUT_HIT);
                rsp_evict <= (outcome == OUT_EVICT);
                rsp_set   <= req_set;
                rsp_way   <= use_way;
            end
        end
    end

    // Statistics counters
    sat_counter #(.CNT_W(CNT_W)) i_hit_cnt (
        .clk (clk), .rst_n (rst_n), .clr (flush),
        .inc (outcome == OUT_HIT), .count (hit_count)
    );

    sat_counter #(.CNT_W(CNT_W)) i_miss_cnt (
        .clk (clk), .rst_n (rst_n), .clr (flush),
        .inc (outcome == OUT_FILL || outcome == OUT_EVICT), .count (miss_count)
    );

    sat_counter #(.CNT_W(CNT_W)) i_evict_cnt (
        .clk (clk), .rst_n (rst_n), .clr (flush),
        .inc (outcome == OUT_EVICT), .count (evict_count)
    );

endmodule

// File: rtl/cache_tag_profiler_checks.sv
// Module: cache_tag_profiler_checks
// Port-level properties of the profiler, bound to every instance.
module cache_tag_profiler_checks #(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 6,
    parameter int INDEX_W  = 6,
    parameter int WAY_W    = 3,
    parameter int CNT_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_evict,
    input logic [INDEX_W-1:0] rsp_set,
    input logic [WAY_W-1:0]   rsp_way,
    input logic [CNT_W-1:0]   hit_count,
    input logic [CNT_W-1:0]   miss_count,
    input logic [CNT_W-1:0]   evict_count
);

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

    assert_set_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_set == $past(req_addr[OFFSET_W +: INDEX_W]));

    assert_hit_no_evict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_evict));

    assert_flush_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready);

    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (hit_count == '0) && (miss_count == '0) && (evict_count == '0));

    assert_hit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && ($past(hit_count) != '1)) |->
            hit_count == $past(hit_count) + 1'b1);

    assert_miss_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && ($past(miss_count) != '1)) |->
            miss_count == $past(miss_count) + 1'b1);

    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (hit_count >= $past(hit_count)) && (evict_count >= $past(evict_count)));

endmodule

bind cache_tag_profiler cache_tag_profiler_checks #(
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W),
    .INDEX_W  (INDEX_W),
    .WAY_W    (WAY_W),
    .CNT_W    (CNT_W)
) i_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_evict   (rsp_evict),
    .rsp_set     (rsp_set),
    .rsp_way     (rsp_way),
    .hit_count   (hit_count),
    .miss_count  (miss_count),
    .evict_count (evict_count)
);

// File: tb/test_cache_tag_profiler.sv
`timescale 1ns/1ps
// Bench: behavioural reference (timestamp LRU) compared every cycle.
module test_cache_tag_profiler;

    localparam int CW   = 8;
    localparam int MAXC = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_evict;
    logic [5:0]  rsp_set;
    logic [2:0]  rsp_way;
    logic [CW-1:0] hit_count, miss_count, evict_count;

    always #2.5 clk = ~clk;

    cache_tag_profiler #(.CNT_W(CW)) i_cache_tag_profiler (
        .clk (clk), .rst_n (rst_n), .flush (flush),
        .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_evict (rsp_evict),
        .rsp_set (rsp_set), .rsp_way (rsp_way),
        .hit_count (hit_count), .miss_count (miss_count), .evict_count (evict_count)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // Reference model state
    bit      m_valid [64][8];
    longint  m_tag   [64][8];
    longint  m_stamp [64][8];
    longint  m_now = 0;
    int      e_hits = 0, e_miss = 0, e_evict = 0;
    bit      e_rv = 0, e_hit = 0, e_ev = 0;
    int      e_set = 0, e_way = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v >= MAXC) ? MAXC : v + 1;
    endfunction

    // Reference update for one cycle's inputs
    task automatic model(input bit v, input logic [31:0] a, input bit f);
        e_rv = 0;
        if (f) begin
            foreach (m_valid[s, w]) m_valid[s][w] = 0;
            e_hits = 0; e_miss = 0; e_evict = 0;
        end else if (v) begin
            int s;
            longint t;
            int way;
            int oldest;
            s = int'(a[11:6]);
            t = longint'(a[31:12]);
            way = -1;
            for (int w = 0; w < 8; w++)
                if (m_valid[s][w] && m_tag[s][w] == t) way = w;
            e_rv = 1; e_set = s;
            if (way >= 0) begin
                e_hit = 1; e_ev = 0;
                e_hits = sat_inc(e_hits);
            end else begin
                e_hit = 0;
                for (int w = 7; w >= 0; w--) if (!m_valid[s][w]) way = w;
                if (way < 0) begin
                    oldest = 0;
                    for (int w = 1; w < 8; w++)
                        if (m_stamp[s][w] < m_stamp[s][oldest]) oldest = w;
                    way = oldest;
                    e_ev = 1;
                    e_evict = sat_inc(e_evict);
                end else begin
                    e_ev = 0;
                end
                e_miss = sat_inc(e_miss);
                m_valid[s][way] = 1;
                m_tag[s][way] = t;
            end
            m_now++;
            m_stamp[s][way] = m_now;
            e_way = way;
        end
    endtask

    // Compare all outputs against the model
    task automatic compare();
        chk("R10 rsp_valid", rsp_valid, e_rv);
        if (e_rv) begin
            chk("R3 rsp_hit", rsp_hit, e_hit);
            chk("R6 rsp_evict", rsp_evict, e_ev);
            chk("R2 rsp_set", rsp_set, e_set);
            chk("R7 rsp_way", rsp_way, e_way);
        end
        chk("R8 hit_count", hit_count, e_hits);
        chk("R8 miss_count", miss_count, e_miss);
        chk("R6 evict_count", evict_count, e_evict);
    endtask

    // Drive one cycle at the falling edge, check after the next one
    task automatic step(input bit v, input logic [31:0] a, input bit f);
        req_valid = v; req_addr = a; flush = f;
        model(v, a, f);
        @(negedge clk);
        compare();
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    logic [31:0] lfsr = 32'hACE1_1234;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        chk("R10 reset rsp_valid", rsp_valid, 0);
        chk("R8 reset hit_count", hit_count, 0);
        chk("R9 reset req_ready", req_ready, 1);

        // R5: 129 bytes from 4096
        for (int i = 0; i < 129; i++) step(1, 32'd4096 + 32'(i), 0);
        chk("R5 misses", miss_count, 3);
        chk("R5 hits", hit_count, 126);
        chk("R8 sum", hit_count + miss_count, 129);

        // R1: other bytes of a resident line hit
        step(1, 32'd4096 + 32'd63, 0);
        chk("R1 offset ignored", rsp_hit, 1);

        // R3: tag differs only in bit 12 -> miss
        step(1, 32'd4096 ^ 32'h1000, 0);
        chk("R3 tag bit12 miss", rsp_hit, 0);

        // R4/R6: stride 4096 to one set, 12 lines
        step(0, 0, 1);
        for (int i = 0; i < 12; i++) step(1, 32'(i) * 32'd4096 + 32'h40, 0);
        chk("R6 stride evictions", evict_count, 4);
        chk("R4 stride misses", miss_count, 12);

        // R7: fill set 5, retouch line 0, new tag must replace line 1's way
        step(0, 0, 1);
        for (int i = 0; i < 8; i++) step(1, (32'(i) << 12) | (32'd5 << 6), 0);
        step(1, (32'd0 << 12) | (32'd5 << 6), 0);
        step(0, 0, 0);
        step(1, (32'd40 << 12) | (32'd5 << 6), 0);
        chk("R7 LRU victim way", rsp_way, 1);
        chk("R6 evict flag", rsp_evict, 1);

        // R9: flush with a request pending is not accepted
        req_valid = 1; req_addr = 32'h140; flush = 1;
        #1 chk("R9 ready low in flush", req_ready, 0);
        model(1, 32'h140, 1);
        @(negedge clk); compare();
        step(1, (32'd0 << 12) | (32'd5 << 6), 0);
        chk("R9 line gone after flush", rsp_hit, 0);

        // Mixed pseudo-random traffic on two sets, twelve tags
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = (32'(lfsr[3:0] % 12) << 12) | (32'(lfsr[8]) << 6) | 32'(lfsr[14:9]);
            if (i % 700 == 699) step(0, 0, 1);
            else step(lfsr[20:19] != 2'b00, a, 0);
        end

        // R11: saturation with narrow counters
        step(0, 0, 1);
        for (int i = 0; i < 300; i++) step(1, 32'h2000, 0);
        chk("R11 hit saturates", hit_count, MAXC);
        chk("R11 miss unaffected", miss_count, 1);

        step(0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule